// File: doc/BRIEF.md
# Multi-Rail Power-Up Sequencer

This controller steps a set of supply rails through a fixed power-up order. It sits between digitized analog status flags and the drivers for the pass-transistor gate ramp, the remote-sense feedback switches, the power-good output and a capacitor delay timer. The status inputs are: supply above its lockout level, all monitors inside their window, the latched breaker fault, gate fully enhanced, sense switches fully enhanced, delay timer expired, and delay timer discharged. All of them are treated as already synchronized and are sampled once per clock.

The sequence moves through eight named steps. Each step's number is shown on the `step` output. **Lockout** (0) waits for the supply to rise above its lockout level. **Monitor wait** (1) waits for a clear breaker and all monitors in window. **First delay** (2) times a settling interval. **Gate ramp** (3) enables the pass-transistor gate until it is fully enhanced. **Sense close** (4) also enables the remote-sense switches until they are fully enhanced. **Second delay** (5) times another interval. **Power good** (6) releases power-good and keeps watching every input. **Tripped** (7) holds while the breaker fault latch is set.

Transitions are as follows. Lockout goes to monitor wait once the supply is up. Monitor wait goes to first delay when the monitors are good. Each delay step goes to the next step once the timer has expired, but only after the timer has first been seen discharged. Gate ramp goes to sense close on full gate enhancement. Sense close goes to second delay on full switch enhancement. Tripped goes to monitor wait when the fault clears. Three interruptions override this order. A low supply sends the block to lockout. A breaker fault sends it to tripped. An error sends it back to monitor wait.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after release, `step` is 0 and `gate_en`, `sw_en`, `pg`, `tmr_run` and `tmr_dis` are all 0.
- R2: With no interruption, the step number advances only by one, in the order 0,1,2,3,4,5,6. The step codes are: 0 lockout, 1 monitor wait, 2 first delay, 3 gate ramp, 4 sense close, 5 second delay, 6 power good, 7 tripped. Each advance happens on the clock edge that samples its condition.
- R3: In steps 2 and 5, `tmr_run` goes high on the cycle after `tmr_clr` is first sampled high in that step. `tmr_done` is ignored until then. The step advances on the edge that samples `tmr_done` high while `tmr_run` is high.
- R4: `tmr_dis` is high in every step except lockout, apart from the cycles in which `tmr_run` is high. In lockout both timer outputs are low.
- R5: `gate_en` is high exactly in steps 3 to 6. All bits of `sw_en` are high exactly in steps 4 to 6. `pg` is high only in step 6.
- R6: `vcc_ok` low at a clock edge sends the block to step 0 from any step. When `vcc_ok` returns with no fault, the next step is 1.
- R7: `brk_flt` high with `vcc_ok` high sends the block to step 7. It stays there while `brk_flt` is high and goes to step 1 on the first edge that samples it low.
- R8: `mon_ok` low in steps 2 to 6, or `gate_full` low in steps 4 to 6, with no lockout and no fault, sends the block to step 1.
- R9: When interruptions coincide, lockout beats fault and fault beats error.
- R10: In step 1 a low `mon_ok` holds the step without counting as an error. In steps 2 and 3, `gate_full` low is not an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_ok | input | 1 | Supply above lockout level |
| mon_ok | input | 1 | All monitors and the supply inside their window |
| brk_flt | input | 1 | Breaker fault latch set |
| gate_full | input | 1 | Pass gate fully enhanced |
| sw_full | input | 1 | Sense switches fully enhanced |
| tmr_clr | input | 1 | Delay timer discharged below its clear level |
| tmr_done | input | 1 | Delay timer reached its trip level |
| tmr_run | output | 1 | Let the delay timer charge |
| tmr_dis | output | 1 | Hold the delay timer discharged |
| gate_en | output | 1 | Pass-transistor gate ramp enable |
| sw_en | output | SW_N | Remote-sense switch enables |
| pg | output | 1 | Power-good |
| step | output | 3 | Current step number |

## Verification
A delay expiry can land in the same cycle as a monitor error or a breaker trip. A lockout can also coincide with a fault. The bench provokes these cases with directed cycles that raise two of these inputs at once, and with long runs of biased random inputs in which such coincidences are frequent. Each cycle's outputs are judged against a bench model that ranks lockout over fault over error over normal advance.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int STEP_W = 3;

    typedef enum logic [STEP_W-1:0] {
        ST_LOCK = 3'd0,
        ST_MONW = 3'd1,
        ST_DLY1 = 3'd2,
        ST_RAMP = 3'd3,
        ST_SNS  = 3'd4,
        ST_DLY2 = 3'd5,
        ST_GOOD = 3'd6,
        ST_TRIP = 3'd7
    } seq_st_e;

    typedef enum logic [1:0] {
        IRQ_NONE = 2'd0,
        IRQ_ERR  = 2'd1,
        IRQ_TRIP = 2'd2,
        IRQ_LOCK = 2'd3
    } irq_e;

endpackage

// File: rtl/pwr_seq_irq.sv
module pwr_seq_irq
    import pwr_seq_pkg::*;
(
    input  seq_st_e state,
    input  logic    vcc_ok,
    input  logic    brk_flt,
    input  logic    mon_ok,
    input  logic    gate_full,
    output irq_e    irq
);
    logic mon_watch;
    logic gate_watch;

    always_comb begin
        mon_watch  = state inside {ST_DLY1, ST_RAMP, ST_SNS, ST_DLY2, ST_GOOD};
        gate_watch = state inside {ST_SNS, ST_DLY2, ST_GOOD};
        if (!vcc_ok) begin
            irq = IRQ_LOCK;
        end else if (brk_flt) begin
            irq = IRQ_TRIP;
        end else if ((mon_watch && !mon_ok) || (gate_watch && !gate_full)) begin
            irq = IRQ_ERR;
        end else begin
            irq = IRQ_NONE;
        end
    end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  irq_e    irq,
    input  logic    mon_ok,
    input  logic    gate_full,
    input  logic    sw_full,
    input  logic    tmr_clr,
    input  logic    tmr_done,
    output seq_st_e state,
    output logic    armed
);
    seq_st_e state_q;
    seq_st_e state_d;
    logic    armed_q;
    logic    in_delay;

    always_comb begin
        state_d = state_q;
        unique case (irq)
            IRQ_LOCK: state_d = ST_LOCK;
            IRQ_TRIP: state_d = ST_TRIP;
            IRQ_ERR:  state_d = ST_MONW;
            IRQ_NONE: begin
                unique case (state_q)
                    ST_LOCK: state_d = ST_MONW;
                    ST_MONW: if (mon_ok) state_d = ST_DLY1;
                    ST_DLY1: if (armed_q && tmr_done) state_d = ST_RAMP;
                    ST_RAMP: if (gate_full) state_d = ST_SNS;
                    ST_SNS:  if (sw_full) state_d = ST_DLY2;
                    ST_DLY2: if (armed_q && tmr_done) state_d = ST_GOOD;
                    ST_GOOD: state_d = ST_GOOD;
                    ST_TRIP: state_d = ST_MONW;
                endcase
            end
        endcase
    end

    assign in_delay = (state_q == ST_DLY1) || (state_q == ST_DLY2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCK;
            armed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            armed_q <= in_delay && (state_d == state_q) && (armed_q || tmr_clr);
        end
    end

    assign state = state_q;
    assign armed = armed_q;
endmodule

// File: rtl/pwr_seq_out.sv
module pwr_seq_out
    import pwr_seq_pkg::*;
#(
    parameter int SW_N = 5
) (
    input  seq_st_e           state,
    input  logic              armed,
    output logic              gate_en,
    output logic [SW_N-1:0]   sw_en,
    output logic              pg,
    output logic              tmr_run,
    output logic              tmr_dis
);
    logic sw_on;

    always_comb begin
        gate_en = state inside {ST_RAMP, ST_SNS, ST_DLY2, ST_GOOD};
        sw_on   = state inside {ST_SNS, ST_DLY2, ST_GOOD};
        pg      = (state == ST_GOOD);
        tmr_run = armed && (state inside {ST_DLY1, ST_DLY2});
        tmr_dis = !tmr_run && (state != ST_LOCK);
    end

    for (genvar i = 0; i < SW_N; i++) begin : g_sw
        assign sw_en[i] = sw_on;
    end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int SW_N = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vcc_ok,
    input  logic              mon_ok,
    input  logic              brk_flt,
    input  logic              gate_full,
    input  logic              sw_full,
    input  logic              tmr_clr,
    input  logic              tmr_done,
    output logic              tmr_run,
    output logic              tmr_dis,
    output logic              gate_en,
    output logic [SW_N-1:0]   sw_en,
    output logic              pg,
    output logic [STEP_W-1:0] step
);
    seq_st_e state;
    irq_e    irq;
    logic    armed;

    pwr_seq_irq u_irq (
        .state     (state),
        .vcc_ok    (vcc_ok),
        .brk_flt   (brk_flt),
        .mon_ok    (mon_ok),
        .gate_full (gate_full),
        .irq       (irq)
    );

    pwr_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq       (irq),
        .mon_ok    (mon_ok),
        .gate_full (gate_full),
        .sw_full   (sw_full),
        .tmr_clr   (tmr_clr),
        .tmr_done  (tmr_done),
        .state     (state),
        .armed     (armed)
    );

    pwr_seq_out #(.SW_N(SW_N)) u_out (
        .state   (state),
        .armed   (armed),
        .gate_en (gate_en),
        .sw_en   (sw_en),
        .pg      (pg),
        .tmr_run (tmr_run),
        .tmr_dis (tmr_dis)
    );

    assign step = state;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
    parameter int SW_N = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            vcc_ok,
    input logic            mon_ok,
    input logic            brk_flt,
    input logic            tmr_clr,
    input logic            tmr_run,
    input logic            gate_en,
    input logic [SW_N-1:0] sw_en,
    input logic            pg,
    input logic [2:0]      step
);
    // R6
    lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_ok |=> (step == 3'd0) && !gate_en && (sw_en == '0) && !pg);

    // R7
    trip_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_ok && brk_flt) |=> (step == 3'd7) && !gate_en && !pg);

    // R5
    pg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg |-> gate_en && (&sw_en));

    // R2
    pg_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg) |-> ($past(step) == 3'd5));

    // R3
    tmr_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_run) |-> $past(tmr_clr));

    // R8
    err_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_ok && !brk_flt && !mon_ok && (step >= 3'd2) && (step <= 3'd6))
        |=> (step == 3'd1));
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.SW_N(SW_N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .vcc_ok  (vcc_ok),
    .mon_ok  (mon_ok),
    .brk_flt (brk_flt),
    .tmr_clr (tmr_clr),
    .tmr_run (tmr_run),
    .gate_en (gate_en),
    .sw_en   (sw_en),
    .pg      (pg),
    .step    (step)
);

// File: tb/pwr_seq_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_bench;
    localparam int SW_N = 5;
    localparam int TLIM = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic v, m, f, g, w, c, d;
    logic tmr_run, tmr_dis, gate_en, pg;
    logic [SW_N-1:0] sw_en;
    logic [2:0] step;

    int n_chk = 0;
    int n_bad = 0;
    bit fin = 1'b0;
    logic [2:0] m_step = 3'd0;
    logic m_arm = 1'b0;

    always #2.5 clk = ~clk;

    pwr_seq_ctrl #(.SW_N(SW_N)) u_pwr_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .vcc_ok(v), .mon_ok(m), .brk_flt(f),
        .gate_full(g), .sw_full(w), .tmr_clr(c), .tmr_done(d),
        .tmr_run(tmr_run), .tmr_dis(tmr_dis), .gate_en(gate_en),
        .sw_en(sw_en), .pg(pg), .step(step)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] ref_next(input logic [2:0] s, input logic a);
        if (!v) return 3'd0;
        if (f) return 3'd7;
        if (s >= 3'd2 && s <= 3'd6 && !m) return 3'd1;
        if (s >= 3'd4 && s <= 3'd6 && !g) return 3'd1;
        case (s)
            3'd0: return 3'd1;
            3'd1: return m ? 3'd2 : 3'd1;
            3'd2: return (a && d) ? 3'd3 : 3'd2;
            3'd3: return g ? 3'd4 : 3'd3;
            3'd4: return w ? 3'd5 : 3'd4;
            3'd5: return (a && d) ? 3'd6 : 3'd5;
            3'd6: return 3'd6;
            default: return 3'd1;
        endcase
    endfunction

    function automatic logic [8:0] exp_vec(input logic [2:0] s, input logic a);
        logic run;
        run = a && (s == 3'd2 || s == 3'd5);
        return {s, (s >= 3'd3 && s <= 3'd6), (s >= 3'd4 && s <= 3'd6),
                (s >= 3'd4 && s <= 3'd6), (s == 3'd6), run, (!run && s != 3'd0)};
    endfunction

    function automatic logic [8:0] act_vec();
        return {step, gate_en, &sw_en, |sw_en, pg, tmr_run, tmr_dis};
    endfunction

    task automatic setin(input logic iv, im, iff_, ig, iw, ic, id);
        v = iv; m = im; f = iff_; g = ig; w = iw; c = ic; d = id;
    endtask

    task automatic tick(input string tag);
        logic [2:0] nxt;
        @(posedge clk);
        nxt = ref_next(m_step, m_arm);
        m_arm = (m_step == 3'd2 || m_step == 3'd5) && (nxt == m_step) && (m_arm || c);
        m_step = nxt;
        @(negedge clk);
        chk(tag, {7'd0, act_vec()}, {7'd0, exp_vec(m_step, m_arm)});
    endtask

    task automatic bring_up();
        setin(1, 1, 0, 1, 1, 1, 1);
        repeat (10) tick("R2 bring-up");
    endtask

    initial begin
        int tcnt;
        int gcnt;
        int scnt;
        logic [2:0] last;
        setin(0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk("R1 in reset", {7'd0, act_vec()}, 16'd0);
        rst_n = 1'b1;
        tick("R1 after release");
        chk("R1 lockout step", {13'd0, step}, 16'd0);

        // R2: full sequence with a plant model of timer, gate and switches
        tcnt = TLIM; gcnt = 0; scnt = 0; last = 3'd0;
        v = 1; m = 1; f = 0;
        for (int k = 0; k < 120; k++) begin
            c = (tcnt == 0); d = (tcnt >= TLIM);
            g = (gcnt >= 3); w = (scnt >= 2);
            tick("R2 sequence");
            if (tmr_run) tcnt = tcnt + 1;
            else if (tmr_dis) tcnt = (tcnt > 2) ? tcnt - 2 : 0;
            gcnt = gate_en ? gcnt + 1 : 0;
            scnt = (|sw_en) ? scnt + 1 : 0;
            if (step != last) chk("R2 order", {13'd0, step}, {13'd0, last + 3'd1});
            last = step;
            if (step == 3'd6) break;
        end
        chk("R2 power good reached", {15'd0, pg}, 16'd1);
        chk("R5 all enables in power good", {13'd0, gate_en, &sw_en, pg}, 16'd7);
        chk("R4 discharge held in power good", {15'd0, tmr_dis}, 16'd1);

        // R6 lockout and recovery
        v = 0;
        tick("R6 lockout");
        chk("R6 outputs off", {12'd0, step, pg}, 16'd0);
        chk("R4 lockout releases discharge", {14'd0, tmr_dis, tmr_run}, 16'd0);
        tick("R6 hold");
        v = 1;
        tick("R6 recover");
        chk("R6 resume at monitor wait", {13'd0, step}, 16'd1);

        // R10 monitor wait holds on bad monitors
        m = 0;
        tick("R10 hold");
        chk("R10 monitor wait holds", {13'd0, step}, 16'd1);

        // R3 timer waits for cleared indication
        setin(1, 1, 0, 0, 0, 0, 1);
        tick("R3 enter delay");
        chk("R3 first delay", {13'd0, step}, 16'd2);
        repeat (3) tick("R3 wait");
        chk("R3 done ignored before clear", {12'd0, step, tmr_run}, {12'd0, 3'd2, 1'b0});
        chk("R4 discharge while waiting", {15'd0, tmr_dis}, 16'd1);
        c = 1;
        tick("R3 clear seen");
        chk("R3 run after clear", {14'd0, tmr_run, tmr_dis}, 16'd2);
        c = 0;
        tick("R3 expire");
        chk("R3 advance on done", {13'd0, step}, 16'd3);
        tick("R10 gate low in ramp");
        chk("R10 ramp holds", {13'd0, step}, 16'd3);
        chk("R5 ramp enables", {13'd0, gate_en, |sw_en, pg}, 16'd4);

        // R8 gate loss after full ramp
        g = 1;
        tick("R8 to sense");
        chk("R8 sense close", {13'd0, step}, 16'd4);
        g = 0;
        tick("R8 gate loss");
        chk("R8 gate loss error", {13'd0, step}, 16'd1);

        // R8 monitor error from power good, coinciding with timer done
        bring_up();
        chk("R2 bring-up reached", {13'd0, step}, 16'd6);
        m = 0;
        tick("R8 monitor error");
        chk("R8 monitor error to wait", {13'd0, step}, 16'd1);

        // R7 fault, and fault over error
        bring_up();
        f = 1; m = 0;
        tick("R7 trip");
        chk("R9 fault beats error", {13'd0, step}, 16'd7);
        m = 1;
        repeat (3) tick("R7 hold");
        chk("R7 held while fault", {12'd0, step, gate_en}, {12'd0, 3'd7, 1'b0});
        f = 0;
        tick("R7 release");
        chk("R7 restart at monitor wait", {13'd0, step}, 16'd1);

        // R9 lockout beats fault
        bring_up();
        v = 0; f = 1;
        tick("R9 lock and fault");
        chk("R9 lockout beats fault", {13'd0, step}, 16'd0);
        v = 1;
        tick("R9 fault after lockout");
        chk("R9 fault after recovery", {13'd0, step}, 16'd7);

        // constrained random
        void'($urandom(32'd2718));
        for (int k = 0; k < 5000; k++) begin
            v = ($urandom % 40) != 0;
            f = ($urandom % 50) == 0;
            m = ($urandom % 14) != 0;
            g = ($urandom % 9) != 0;
            w = ($urandom % 3) != 0;
            c = ($urandom % 2) != 0;
            d = ($urandom % 3) == 0;
            tick("R9/R10 random");
        end

        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!fin) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule